// File: doc/BRIEF.md
# Serial Clock-Calendar and Parameter RAM Slave

This block is a small clock-calendar and non-volatile parameter store that a host processor talks to by bit-banging three bits of a byte-wide control register. Each host write to that register presents an enable bit, a serial clock bit and a data bit. While enable is high, every high-to-low step of the clock bit moves one bit of a 16-bit frame. The first eight bits form a command and the last eight bits form a data byte.

Commands read a 32-byte parameter RAM, read a status or control byte, read one of six calendar fields in packed BCD, write a RAM byte, or clear two status flags. The status clear also sends a one-cycle pulse to the interrupt controller so that it can drop the matching request. During the data half of a read frame, the block returns one bit per clock edge on `rd_bit`, most significant bit first. The current time comes in on binary input ports. Keeping the time itself is left to logic outside the block.

Top module: `rtc_bitbang_slave`

## Requirements
- R1: A control write (`wr_en` high) carries the frame enable in bit 0 (active high), the serial clock in bit 1 and the serial data in bit 2 of `wr_byte`.
- R2: A bit is accepted only on a control write that has enable high, clock bit 0, and clock bit 1 in the previous control write. Writes that leave the clock low or high, and cycles with `wr_en` low, move no bit.
- R3: Accepted bits 0–7 of a frame form the command, MSB first. Bits 8–15 form the data byte, MSB first. Once 16 bits have been accepted, further clock edges are ignored until enable is written low.
- R4: A control write with enable low aborts the frame: the bit count, command and data byte return to zero, and a partial frame changes no stored state.
- R5: For commands 0x00–0x1F, after the accepted edge of frame bit 8+k (k = 0..7), `rd_bit` equals bit 7−k of RAM byte [command].
- R6: Command 0x30 returns the status byte and command 0x31 returns the control byte, in the same bit order as R5.
- R7: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day of month, month (1–12 as given) and two-digit year in packed BCD, with tens in bits 7:4 and units in bits 3:0. The remaining codes 0x20–0x2F return 0x00.
- R8: When bit 15 of a frame whose command is 0x80–0x9F is accepted, the data byte is stored in RAM byte [command − 0x80]. No other command writes the RAM.
- R9: When bit 15 of a frame with command 0xB1 is accepted and data bit 2 is 1, status bits 4 and 3 are cleared and `irq_clr` is high for exactly the next cycle. With data bit 2 equal to 0, nothing changes.
- R10: After reset, status is 0x90, control is 0x00, RAM byte i holds (43·i + 23) mod 256, and `rd_bit` and `irq_clr` are 0.
- R11: On any other control write, `rd_bit` takes the host data bit of that write. `rd_bit` holds while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-byte write strobe |
| wr_byte | input | 8 | Control byte: enable, serial clock, serial data |
| tm_sec | input | 6 | Seconds 0–59, binary |
| tm_min | input | 6 | Minutes 0–59, binary |
| tm_hour | input | 5 | Hours 0–23, binary |
| tm_mday | input | 5 | Day of month 1–31, binary |
| tm_month | input | 4 | Month 1–12, binary |
| tm_year | input | 7 | Year within century 0–99, binary |
| rd_bit | output | 1 | Registered serial data returned to the host |
| irq_clr | output | 1 | One-cycle pulse that clears the interrupt-status flag |

## Verification
The bench targets the edge detector. It toggles the data bit while the clock is low and moves the clock with the strobe low. A design that samples levels instead of edges, or that ignores the strobe, would then shift in a corrupted command and read the wrong RAM byte. The bench also sends 32 clock edges after a completed write frame, with the second half encoding a new write. A design that does not stop at 16 bits would wrap its counter and overwrite the byte.

Further cases cover:
- Write commands just outside the RAM window (0xA0). A design with a loose range decode would overwrite byte 0.
- An aborted half frame. A premature write would show up here.
- A status clear with the trigger bit low, which must neither clear the flags nor pulse the output.
- The unused time codes, which must read as zero and not as stale host data.

// File: rtl/rtc_bb_pkg.sv
package rtc_bb_pkg;

   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_TIME_HI    = 8'h20;
   localparam logic [BYTE_W-1:0] OP_STATUS_RD  = 8'h30;
   localparam logic [BYTE_W-1:0] OP_CTRL_RD    = 8'h31;
   localparam logic [BYTE_W-1:0] OP_RAM_WR     = 8'h80;
   localparam logic [BYTE_W-1:0] OP_FLAG_CLEAR = 8'hB1;

   typedef enum logic [2:0] {
      SRC_HOST,
      SRC_RAM,
      SRC_TIME,
      SRC_STATUS,
      SRC_CTRL
   } rd_src_e;

   // power-on image of one parameter RAM byte
   function automatic logic [BYTE_W-1:0] ram_seed(input int unsigned idx);
      return BYTE_W'((idx * 43 + 23) % 256);
   endfunction

   // packed BCD of a binary value below 100
   function automatic logic [BYTE_W-1:0] to_bcd(input logic [6:0] v);
      return {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

endpackage

// File: rtl/rtc_bb_frame.sv
module rtc_bb_frame
   import rtc_bb_pkg::*;
#(
   parameter int unsigned CMD_W  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned EN_BIT = 0,
   parameter int unsigned CK_BIT = 1,
   parameter int unsigned DT_BIT = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [BYTE_W-1:0]           wr_byte,
   output logic [CMD_W-1:0]            cmd_q,
   output logic [DATA_W-1:0]           val_next,
   output logic [$clog2(DATA_W)-1:0]   slot_idx,
   output logic                        rd_slot,
   output logic                        done,
   output logic                        host_bit
);

   localparam int unsigned FRAME_LEN = CMD_W + DATA_W;
   localparam int unsigned PH_W      = $clog2(FRAME_LEN + 1);
   localparam int unsigned IX_W      = $clog2(DATA_W);

   if ((1 << IX_W) != DATA_W) begin : g_bad_data_w
      $error("DATA_W must be a power of two");
   end

   logic [PH_W-1:0]   phase_q;
   logic [DATA_W-1:0] val_q;
   logic              prev_ck_q;
   logic              en_in, ck_in;
   logic              fall, in_cmd;
   logic [PH_W-1:0]   off;

   assign en_in    = wr_byte[EN_BIT];
   assign ck_in    = wr_byte[CK_BIT];
   assign host_bit = wr_byte[DT_BIT];

   // falling clock step, frame open, not yet complete
   assign fall     = wr_en & en_in & prev_ck_q & ~ck_in &
                     (phase_q < PH_W'(FRAME_LEN));
   assign in_cmd   = phase_q < PH_W'(CMD_W);
   assign off      = phase_q - PH_W'(CMD_W);
   assign slot_idx = off[IX_W-1:0];
   assign rd_slot  = fall & ~in_cmd;
   assign done     = fall & (phase_q == PH_W'(FRAME_LEN - 1));
   assign val_next = {val_q[DATA_W-2:0], host_bit};

   logic unused_frame;
   assign unused_frame = ^{wr_byte, off};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ck_q <= 1'b0;
         phase_q   <= '0;
         cmd_q     <= '0;
         val_q     <= '0;
      end else if (wr_en) begin
         prev_ck_q <= ck_in;
         if (!en_in) begin
            phase_q <= '0;
            cmd_q   <= '0;
            val_q   <= '0;
         end else if (fall) begin
            if (in_cmd) begin
               cmd_q <= {cmd_q[CMD_W-2:0], host_bit};
            end else begin
               val_q <= val_next;
            end
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   assert_phase_cap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= PH_W'(FRAME_LEN));

   assert_abort_clears_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_byte[EN_BIT]) |=> (phase_q == '0 && cmd_q == '0 && val_q == '0));

   assert_idle_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(phase_q) && $stable(cmd_q) && $stable(val_q)));

endmodule

// File: rtl/rtc_bb_store.sv
module rtc_bb_store
   import rtc_bb_pkg::*;
#(
   parameter int unsigned   RAM_WORDS      = 32,
   parameter int unsigned   CMD_W          = 8,
   parameter int unsigned   DATA_W         = 8,
   parameter logic [7:0]    STATUS_INIT    = 8'h90,
   parameter logic [7:0]    CLEAR_MASK     = 8'h18,
   parameter int unsigned   CLEAR_TRIG_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [DATA_W-1:0] val_next,
   output logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] status_q,
   output logic              clear_hit
);

   localparam int unsigned AW = $clog2(RAM_WORDS);

   if (CLEAR_TRIG_BIT >= DATA_W) begin : g_bad_trig
      $error("CLEAR_TRIG_BIT outside data byte");
   end

   logic [DATA_W-1:0] mem_q [RAM_WORDS];
   logic              wr_hit;
   logic [CMD_W-1:0]  wr_off;

   assign wr_off    = cmd - CMD_W'(OP_RAM_WR);
   assign wr_hit    = done && (cmd >= CMD_W'(OP_RAM_WR)) &&
                      (cmd < CMD_W'(OP_RAM_WR) + CMD_W'(RAM_WORDS));
   assign clear_hit = done && (cmd == CMD_W'(OP_FLAG_CLEAR)) && val_next[CLEAR_TRIG_BIT];
   assign rd_word   = mem_q[cmd[AW-1:0]];

   logic unused_store;
   assign unused_store = ^wr_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RAM_WORDS; i++) begin
            mem_q[i] <= DATA_W'(ram_seed(i));
         end
      end else if (wr_hit) begin
         mem_q[wr_off[AW-1:0]] <= val_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= DATA_W'(STATUS_INIT);
      end else if (clear_hit) begin
         status_q <= status_q & ~DATA_W'(CLEAR_MASK);
      end
   end

   assert_flags_never_set_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & DATA_W'(CLEAR_MASK)) & ~($past(status_q) & DATA_W'(CLEAR_MASK))) == '0);

   assert_ram_only_on_done_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(mem_q[0]));

endmodule

// File: rtl/rtc_bb_time.sv
module rtc_bb_time
   import rtc_bb_pkg::*;
#(
   parameter int unsigned SEC_W  = 6,
   parameter int unsigned MIN_W  = 6,
   parameter int unsigned HOUR_W = 5,
   parameter int unsigned DAY_W  = 5,
   parameter int unsigned MON_W  = 4,
   parameter int unsigned YEAR_W = 7
) (
   input  logic [SEC_W-1:0]  tm_sec,
   input  logic [MIN_W-1:0]  tm_min,
   input  logic [HOUR_W-1:0] tm_hour,
   input  logic [DAY_W-1:0]  tm_mday,
   input  logic [MON_W-1:0]  tm_month,
   input  logic [YEAR_W-1:0] tm_year,
   input  logic [3:0]        sel,
   output logic [BYTE_W-1:0] bcd_out
);

   if (SEC_W > 7 || MIN_W > 7 || HOUR_W > 7 || DAY_W > 7 || MON_W > 7 || YEAR_W > 7)
   begin : g_bad_width
      $error("time fields must fit in 7 bits");
   end

   logic [BYTE_W-1:0] slot [16];

   for (genvar k = 0; k < 16; k++) begin : g_slot
      if (k == 0) begin : g_sec
         assign slot[k] = to_bcd(7'(tm_sec));
      end else if (k == 1) begin : g_min
         assign slot[k] = to_bcd(7'(tm_min));
      end else if (k == 2) begin : g_hour
         assign slot[k] = to_bcd(7'(tm_hour));
      end else if (k == 4) begin : g_day
         assign slot[k] = to_bcd(7'(tm_mday));
      end else if (k == 5) begin : g_mon
         assign slot[k] = to_bcd(7'(tm_month));
      end else if (k == 6) begin : g_year
         assign slot[k] = to_bcd(7'(tm_year));
      end else begin : g_zero
         assign slot[k] = '0;
      end
   end

   assign bcd_out = slot[sel];

endmodule

// File: rtl/rtc_bitbang_slave.sv
module rtc_bitbang_slave
   import rtc_bb_pkg::*;
#(
   parameter int unsigned RAM_WORDS      = 32,
   parameter logic [7:0]  STATUS_INIT    = 8'h90,
   parameter logic [7:0]  CTRL_INIT      = 8'h00,
   parameter logic [7:0]  CLEAR_MASK     = 8'h18,
   parameter int unsigned CLEAR_TRIG_BIT = 2,
   parameter int unsigned EN_BIT         = 0,
   parameter int unsigned CK_BIT         = 1,
   parameter int unsigned DT_BIT         = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   input  logic [5:0] tm_sec,
   input  logic [5:0] tm_min,
   input  logic [4:0] tm_hour,
   input  logic [4:0] tm_mday,
   input  logic [3:0] tm_month,
   input  logic [6:0] tm_year,
   output logic       rd_bit,
   output logic       irq_clr
);

   localparam int unsigned CMD_W  = BYTE_W;
   localparam int unsigned DATA_W = BYTE_W;
   localparam int unsigned IX_W   = $clog2(DATA_W);

   if (EN_BIT == CK_BIT || EN_BIT == DT_BIT || CK_BIT == DT_BIT ||
       EN_BIT >= BYTE_W || CK_BIT >= BYTE_W || DT_BIT >= BYTE_W) begin : g_bad_pins
      $error("control bit positions must be distinct and inside the byte");
   end
   if (RAM_WORDS < 2 || RAM_WORDS > 32 || (RAM_WORDS & (RAM_WORDS - 1)) != 0) begin : g_bad_ram
      $error("RAM_WORDS must be a power of two from 2 to 32");
   end

   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] val_next;
   logic [IX_W-1:0]   slot_idx;
   logic              rd_slot, done, host_bit;
   logic [DATA_W-1:0] ram_word, status_q, time_byte;
   logic              clear_hit;
   rd_src_e           src;
   logic [DATA_W-1:0] src_byte;
   logic              rd_q, irq_q;

   rtc_bb_frame #(
      .CMD_W  (CMD_W),
      .DATA_W (DATA_W),
      .EN_BIT (EN_BIT),
      .CK_BIT (CK_BIT),
      .DT_BIT (DT_BIT)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_byte  (wr_byte),
      .cmd_q    (cmd_q),
      .val_next (val_next),
      .slot_idx (slot_idx),
      .rd_slot  (rd_slot),
      .done     (done),
      .host_bit (host_bit)
   );

   rtc_bb_store #(
      .RAM_WORDS      (RAM_WORDS),
      .CMD_W          (CMD_W),
      .DATA_W         (DATA_W),
      .STATUS_INIT    (STATUS_INIT),
      .CLEAR_MASK     (CLEAR_MASK),
      .CLEAR_TRIG_BIT (CLEAR_TRIG_BIT)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .cmd       (cmd_q),
      .val_next  (val_next),
      .rd_word   (ram_word),
      .status_q  (status_q),
      .clear_hit (clear_hit)
   );

   rtc_bb_time u_time (
      .tm_sec   (tm_sec),
      .tm_min   (tm_min),
      .tm_hour  (tm_hour),
      .tm_mday  (tm_mday),
      .tm_month (tm_month),
      .tm_year  (tm_year),
      .sel      (cmd_q[3:0]),
      .bcd_out  (time_byte)
   );

   // command class decode for the read half of a frame
   always_comb begin
      if (cmd_q < CMD_W'(RAM_WORDS)) begin
         src = SRC_RAM;
      end else if (cmd_q[CMD_W-1:4] == OP_TIME_HI[CMD_W-1:4]) begin
         src = SRC_TIME;
      end else if (cmd_q == OP_STATUS_RD) begin
         src = SRC_STATUS;
      end else if (cmd_q == OP_CTRL_RD) begin
         src = SRC_CTRL;
      end else begin
         src = SRC_HOST;
      end
   end

   always_comb begin
      unique case (src)
         SRC_RAM:    src_byte = ram_word;
         SRC_TIME:   src_byte = time_byte;
         SRC_STATUS: src_byte = status_q;
         SRC_CTRL:   src_byte = DATA_W'(CTRL_INIT);
         default:    src_byte = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= clear_hit;
         if (wr_en) begin
            if (rd_slot && src != SRC_HOST) begin
               rd_q <= src_byte[IX_W'(DATA_W - 1) - slot_idx];
            end else begin
               rd_q <= host_bit;
            end
         end
      end
   end

   assign rd_bit  = rd_q;
   assign irq_clr = irq_q;

   assert_single_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !irq_clr);

   assert_pulse_after_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |-> ((status_q & DATA_W'(CLEAR_MASK)) == '0));

   assert_quiet_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_bit));

endmodule

// File: tb/test_rtc_bitbang_slave.sv
module test_rtc_bitbang_slave;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_byte;
   logic [5:0] tm_sec;
   logic [5:0] tm_min;
   logic [4:0] tm_hour;
   logic [4:0] tm_mday;
   logic [3:0] tm_month;
   logic [6:0] tm_year;
   logic       rd_bit;
   logic       irq_clr;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   rtc_bitbang_slave i_rtc_bitbang_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_byte  (wr_byte),
      .tm_sec   (tm_sec),
      .tm_min   (tm_min),
      .tm_hour  (tm_hour),
      .tm_mday  (tm_mday),
      .tm_month (tm_month),
      .tm_year  (tm_year),
      .rd_bit   (rd_bit),
      .irq_clr  (irq_clr)
   );

   function automatic logic [7:0] seed(input int i);
      return 8'((43 * i + 23) % 256);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_byte = b;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // one serial bit: clock high then clock low, enable held
   task automatic send_bit(input logic d, input bit glitch);
      if (glitch) begin
         put({5'b0, ~d, 2'b01});
         @(negedge clk);
         wr_byte = {5'b0, d, 2'b11};
         @(negedge clk);
         wr_byte = {5'b0, d, 2'b01};
      end
      put({5'b0, d, 2'b11});
      put({5'b0, d, 2'b01});
   endtask

   task automatic run_frame(input logic [7:0] cmd, input logic [7:0] val,
                            input int extra, input logic [31:0] extra_bits,
                            input bit glitch,
                            output logic [7:0] got, output logic irq_seen);
      put(8'h01);
      for (int p = 0; p < 16; p++) begin
         logic d;
         d = (p < 8) ? cmd[7 - p] : val[15 - p];
         send_bit(d, glitch);
         if (p >= 8) got[15 - p] = rd_bit;
      end
      irq_seen = irq_clr;
      for (int e = 0; e < extra; e++) begin
         send_bit(extra_bits[31 - e], 1'b0);
      end
      put(8'h00);
   endtask

   task automatic read_byte(input logic [7:0] cmd, output logic [7:0] got);
      logic irq;
      run_frame(cmd, 8'hFF, 0, 32'h0, 1'b0, got, irq);
   endtask

   task automatic write_byte(input logic [7:0] cmd, input logic [7:0] val);
      logic [7:0] g;
      logic irq;
      run_frame(cmd, val, 0, 32'h0, 1'b0, g, irq);
   endtask

   task automatic t_reset;
      logic [7:0] g;
      chk("R10 rd_bit after reset", rd_bit, 1'b0);
      chk("R10 irq_clr after reset", irq_clr, 1'b0);
      read_byte(8'h30, g); chk("R10 R6 status reset", g, 8'h90);
      read_byte(8'h31, g); chk("R10 R6 control reset", g, 8'h00);
      read_byte(8'h00, g); chk("R10 R5 ram[0] image", g, seed(0));
      read_byte(8'h1F, g); chk("R10 R5 ram[31] image", g, seed(31));
      read_byte(8'h06, g); chk("R10 R5 ram[6] image", g, seed(6));
   endtask

   task automatic t_ram_rw;
      logic [7:0] g;
      write_byte(8'h85, 8'h3C);
      read_byte(8'h05, g); chk("R8 R5 write 0x85 read 0x05", g, 8'h3C);
      write_byte(8'h9F, 8'hA5);
      read_byte(8'h1F, g); chk("R8 R5 write 0x9F read 0x1F", g, 8'hA5);
      write_byte(8'hA0, 8'h66);
      read_byte(8'h00, g); chk("R8 cmd 0xA0 leaves ram[0]", g, seed(0));
      read_byte(8'h04, g); chk("R8 neighbour ram[4] untouched", g, seed(4));
   endtask

   task automatic t_time;
      logic [7:0] g;
      read_byte(8'h20, g); chk("R7 seconds", g, 8'h47);
      read_byte(8'h21, g); chk("R7 minutes", g, 8'h05);
      read_byte(8'h22, g); chk("R7 hours", g, 8'h23);
      read_byte(8'h24, g); chk("R7 day", g, 8'h31);
      read_byte(8'h25, g); chk("R7 month", g, 8'h12);
      read_byte(8'h26, g); chk("R7 year", g, 8'h09);
      read_byte(8'h23, g); chk("R7 code 0x23 zero", g, 8'h00);
      read_byte(8'h2F, g); chk("R7 code 0x2F zero", g, 8'h00);
   endtask

   task automatic t_clear;
      logic [7:0] g;
      logic irq;
      run_frame(8'hB1, 8'hFB, 0, 32'h0, 1'b0, g, irq);
      chk("R9 no pulse without trigger bit", irq, 1'b0);
      read_byte(8'h30, g); chk("R9 status kept without trigger", g, 8'h90);
      put(8'h01);
      for (int p = 0; p < 16; p++) begin
         logic [15:0] fr;
         fr = {8'hB1, 8'h04};
         send_bit(fr[15 - p], 1'b0);
      end
      chk("R9 pulse after clear frame", irq_clr, 1'b1);
      @(negedge clk);
      chk("R9 pulse lasts one cycle", irq_clr, 1'b0);
      put(8'h00);
      read_byte(8'h30, g); chk("R9 status flags cleared", g, 8'h80);
   endtask

   task automatic t_abort;
      logic [7:0] g;
      put(8'h01);
      for (int p = 0; p < 12; p++) begin
         logic [15:0] fr;
         fr = {8'h86, 8'hF0};
         send_bit(fr[15 - p], 1'b0);
      end
      put(8'h00);
      read_byte(8'h06, g); chk("R4 aborted write leaves ram[6]", g, seed(6));
   endtask

   task automatic t_overrun;
      logic [7:0] g;
      logic irq;
      run_frame(8'h86, 8'h5A, 32, {16'hFFFF, 8'h86, 8'h00}, 1'b0, g, irq);
      read_byte(8'h06, g); chk("R3 edges after bit 15 ignored", g, 8'h5A);
   endtask

   task automatic t_noedge;
      logic [7:0] g;
      logic irq;
      run_frame(8'h05, 8'hFF, 0, 32'h0, 1'b1, g, irq);
      chk("R2 R1 data toggles and unstrobed clocks ignored", g, 8'h3C);
   endtask

   task automatic t_hostbit;
      put(8'h05);
      chk("R11 rd_bit follows host data 1", rd_bit, 1'b1);
      @(negedge clk);
      wr_byte = 8'h00;
      @(negedge clk);
      chk("R11 rd_bit holds without strobe", rd_bit, 1'b1);
      put(8'h01);
      chk("R11 rd_bit follows host data 0", rd_bit, 1'b0);
      put(8'h00);
   endtask

   initial begin
      rst_n    = 1'b0;
      wr_en    = 1'b0;
      wr_byte  = 8'h00;
      tm_sec   = 6'd47;
      tm_min   = 6'd5;
      tm_hour  = 5'd23;
      tm_mday  = 5'd31;
      tm_month = 4'd12;
      tm_year  = 7'd9;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ram_rw();
      t_time();
      t_clear();
      t_abort();
      t_overrun();
      t_noedge();
      t_hostbit();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule